// File: doc/BRIEF.md
# PFM Boost Converter Switch Sequencer

This block is the digital timing core of a pulse-frequency-modulated boost converter. It receives three comparator decisions that are already digital. The first says the output feedback has fallen below the reference. The second says the coil current has reached its limit. The third says the voltage across the synchronous rectifier has collapsed, which means the coil current is close to zero. From these it drives two gate commands: one for the low-side switch and one for the synchronous rectifier switch.

There is no fixed switching frequency. A conversion cycle is launched only when the feedback falls below the reference and the previous off interval has run long enough. The low-side switch then conducts for a fixed maximum time, and the current limit can end that time early. The rectifier is turned on only after a break-before-make gap. It is turned off either by the zero-crossing comparator or by a new cycle request; a request adds a second gap before the low-side switch turns on again. All intervals are clock counts set by parameters. A parameter selects a diode-rectified variant for an auxiliary channel, in which the rectifier gate is never driven.

Each comparator input passes through its own synchronizer. An enable input forces both gates off and returns the sequencer to idle.

Top module: `pfm_boost_seq`

## Requirements
- R1: A low-side pulse starts only while the synchronized feedback-low input is 1 and the minimum off interval has elapsed. From idle, the low-side gate rises on the third rising clock edge after the feedback-low input goes high.
- R2: With no current limit, the low-side gate stays high for exactly TON_CYC clock cycles (default 34).
- R3: If the current-limit input goes high during the k-th high cycle of the low-side gate, the gate goes low after k+2 cycles, or after TON_CYC cycles if that is earlier. The gate does not rise again until a new cycle starts.
- R4: In synchronous mode, after the low-side gate falls, both gates stay low for exactly DT_HI_CYC cycles (default 2), and then the rectifier gate rises.
- R5: If a new cycle is requested while the rectifier gate is high, the rectifier gate falls first. Both gates then stay low for exactly DT_LO_CYC cycles (default 2) before the low-side gate rises.
- R6: If the zero-crossing input goes high during the first high cycle of the rectifier gate, the rectifier gate is high for exactly 3 cycles. It stays low afterwards until a later pulse.
- R7: The low-side gate stays low for at least TOFF_CYC cycles between pulses. Default TOFF_CYC is 13 for the main channel and 4 for the auxiliary configuration. When the request waits in the rectifier phase, the low time is TOFF_CYC+DT_LO_CYC.
- R8: With DIODE_MODE=1, the rectifier gate never goes high. The low-side gate follows the same start, on-time, limit and minimum-off rules.
- R9: When the enable input is 0 at a rising edge, both gates are low after that edge, and no pulse starts while enable stays 0. One clock after enable returns to 1, a pulse starts if feedback-low is 1.
- R10: The two gate outputs are never high in the same cycle.
- R11: While reset is asserted, both gate outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| en | input | 1 | Synchronous enable; 0 forces both gates off and returns to idle |
| fb_low_i | input | 1 | Comparator: output feedback below reference (asynchronous) |
| ilim_i | input | 1 | Comparator: coil current at limit (asynchronous) |
| zc_i | input | 1 | Comparator: rectifier voltage drop shows current near zero (asynchronous) |
| lsw_gate_o | output | 1 | Low-side switch gate command |
| rect_gate_o | output | 1 | Synchronous rectifier gate command |

## Verification
A table of current-limit arrival times is applied to the on-phase. An early arrival, a mid-pulse arrival, arrivals at the on-time boundary and no arrival together separate the limit path from the on-time counter and show which one wins at the edge. A constant feedback-low request with the limit always active forces continuous conduction. This pattern separates the minimum-off wait from the rectifier-to-switch dead time, and the same stimulus drives a diode-mode instance to show that its off interval is the short one and that its rectifier stays low. Enable is dropped in the middle of a pulse and held low against a standing request, which shows the forced-off path and the restart.

// File: rtl/pfm_seq_pkg.sv
package pfm_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ON   = 3'd1,
    ST_DHI  = 3'd2,
    ST_RECT = 3'd3,
    ST_DLO  = 3'd4
  } pfm_state_e;

  typedef struct packed {
    logic fb_low;
    logic ilim;
    logic zc;
  } pfm_cmp_t;

  localparam int CMP_W = $bits(pfm_cmp_t);

endpackage

// File: rtl/pfm_sync.sv
module pfm_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= '0;
    end else begin
      stg_q[0] <= d;
      for (int i = 1; i < STAGES; i++) begin
        stg_q[i] <= stg_q[i-1];
      end
    end
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/pfm_tmr.sv
module pfm_tmr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] ld_val,
  output logic         done
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = clr || load || (cnt_q != '0);
    cnt_d  = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (load) begin
      cnt_d = ld_val;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/pfm_fsm.sv
module pfm_fsm
  import pfm_seq_pkg::*;
#(
  parameter int CNT_W      = 8,
  parameter int TON_CYC    = 34,
  parameter int DT_HI_CYC  = 2,
  parameter int DT_LO_CYC  = 2,
  parameter int DIODE_MODE = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             fb_s,
  input  logic             ilim_s,
  input  logic             zc_s,
  input  logic             ph_done,
  input  logic             toff_done,
  output logic             ph_clr,
  output logic             ph_load,
  output logic [CNT_W-1:0] ph_val,
  output logic             toff_clr,
  output logic             toff_load,
  output logic             lsw_o,
  output logic             rect_o
);

  localparam logic [CNT_W-1:0] TON_LD = CNT_W'(TON_CYC - 1);
  localparam logic [CNT_W-1:0] DHI_LD = CNT_W'(DT_HI_CYC - 1);
  localparam logic [CNT_W-1:0] DLO_LD = CNT_W'(DT_LO_CYC - 1);
  localparam logic             SYNC_RECT = (DIODE_MODE == 0);

  pfm_state_e st_q;
  pfm_state_e st_d;
  logic       start;
  logic       lsw_d;
  logic       rect_d;

  assign start = fb_s && toff_done;

  always_comb begin
    st_d      = st_q;
    ph_clr    = 1'b0;
    ph_load   = 1'b0;
    ph_val    = '0;
    toff_clr  = 1'b0;
    toff_load = 1'b0;
    if (!en) begin
      st_d     = ST_IDLE;
      ph_clr   = 1'b1;
      toff_clr = 1'b1;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (start) begin
            st_d    = ST_ON;
            ph_load = 1'b1;
            ph_val  = TON_LD;
          end
        end
        ST_ON: begin
          if (ilim_s || ph_done) begin
            toff_load = 1'b1;
            if (SYNC_RECT) begin
              st_d    = ST_DHI;
              ph_load = 1'b1;
              ph_val  = DHI_LD;
            end else begin
              st_d = ST_IDLE;
            end
          end
        end
        ST_DHI: begin
          if (ph_done) begin
            st_d = ST_RECT;
          end
        end
        ST_RECT: begin
          if (zc_s) begin
            st_d = ST_IDLE;
          end else if (start) begin
            st_d    = ST_DLO;
            ph_load = 1'b1;
            ph_val  = DLO_LD;
          end
        end
        ST_DLO: begin
          if (ph_done) begin
            st_d    = ST_ON;
            ph_load = 1'b1;
            ph_val  = TON_LD;
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  assign lsw_d  = (st_d == ST_ON);
  assign rect_d = (st_d == ST_RECT) && SYNC_RECT;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      lsw_o  <= 1'b0;
      rect_o <= 1'b0;
    end else begin
      st_q   <= st_d;
      lsw_o  <= lsw_d;
      rect_o <= rect_d;
    end
  end

endmodule

// File: rtl/pfm_boost_seq.sv
module pfm_boost_seq
  import pfm_seq_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int TON_CYC     = 34,
  parameter int TOFF_CYC    = 13,
  parameter int DT_HI_CYC   = 2,
  parameter int DT_LO_CYC   = 2,
  parameter int SYNC_STAGES = 2,
  parameter int DIODE_MODE  = 0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic fb_low_i,
  input  logic ilim_i,
  input  logic zc_i,
  output logic lsw_gate_o,
  output logic rect_gate_o
);

  localparam logic [CNT_W-1:0] TOFF_LD = CNT_W'(TOFF_CYC - 1);

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q;
  logic rst_sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  // comparator synchronizers
  pfm_cmp_t         cmp_raw;
  logic [CMP_W-1:0] cmp_sync;
  pfm_cmp_t         cmp_s;
  logic             fb_s;
  logic             ilim_s;
  logic             zc_s;

  assign cmp_raw.fb_low = fb_low_i;
  assign cmp_raw.ilim   = ilim_i;
  assign cmp_raw.zc     = zc_i;

  pfm_sync #(.W(CMP_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_sync_q),
    .d     (cmp_raw),
    .q     (cmp_sync)
  );

  assign cmp_s  = pfm_cmp_t'(cmp_sync);
  assign fb_s   = cmp_s.fb_low;
  assign ilim_s = cmp_s.ilim;
  assign zc_s   = cmp_s.zc;

  // timers: phase (on-time / dead times) and minimum off-time
  logic             ph_clr;
  logic             ph_load;
  logic [CNT_W-1:0] ph_val;
  logic             ph_done;
  logic             toff_clr;
  logic             toff_load;
  logic             toff_done;

  pfm_tmr #(.W(CNT_W)) u_ph_tmr (
    .clk    (clk),
    .rst_n  (rst_sync_q),
    .clr    (ph_clr),
    .load   (ph_load),
    .ld_val (ph_val),
    .done   (ph_done)
  );

  pfm_tmr #(.W(CNT_W)) u_toff_tmr (
    .clk    (clk),
    .rst_n  (rst_sync_q),
    .clr    (toff_clr),
    .load   (toff_load),
    .ld_val (TOFF_LD),
    .done   (toff_done)
  );

  pfm_fsm #(
    .CNT_W      (CNT_W),
    .TON_CYC    (TON_CYC),
    .DT_HI_CYC  (DT_HI_CYC),
    .DT_LO_CYC  (DT_LO_CYC),
    .DIODE_MODE (DIODE_MODE)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .en        (en),
    .fb_s      (fb_s),
    .ilim_s    (ilim_s),
    .zc_s      (zc_s),
    .ph_done   (ph_done),
    .toff_done (toff_done),
    .ph_clr    (ph_clr),
    .ph_load   (ph_load),
    .ph_val    (ph_val),
    .toff_clr  (toff_clr),
    .toff_load (toff_load),
    .lsw_o     (lsw_gate_o),
    .rect_o    (rect_gate_o)
  );

endmodule

// File: rtl/pfm_seq_chk.sv
module pfm_seq_chk #(
  parameter int DIODE_MODE = 0
) (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic lsw,
  input logic rect,
  input logic ilim_s,
  input logic zc_s
);

  AST_GATES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n) !(lsw && rect)); // R10
  AST_DEAD_BEFORE_RECT: assert property (@(posedge clk) disable iff (!rst_n) $rose(rect) |-> !$past(lsw)); // R4
  AST_DEAD_BEFORE_LSW: assert property (@(posedge clk) disable iff (!rst_n) $rose(lsw) |-> !$past(rect)); // R5
  AST_LIMIT_ENDS_ON: assert property (@(posedge clk) disable iff (!rst_n) (lsw && ilim_s) |=> !lsw); // R3
  AST_ZC_ENDS_RECT: assert property (@(posedge clk) disable iff (!rst_n) (rect && zc_s) |=> !rect); // R6
  AST_DISABLE_OFF: assert property (@(posedge clk) disable iff (!rst_n) !en |=> (!lsw && !rect)); // R9

  if (DIODE_MODE != 0) begin : g_diode
    AST_NO_RECT_DIODE: assert property (@(posedge clk) disable iff (!rst_n) !rect); // R8
  end

endmodule

bind pfm_boost_seq pfm_seq_chk #(.DIODE_MODE(DIODE_MODE)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .en     (en),
  .lsw    (lsw_gate_o),
  .rect   (rect_gate_o),
  .ilim_s (ilim_s),
  .zc_s   (zc_s)
);

// File: tb/tb_pfm_boost_seq.sv
`timescale 1ns/1ps
module tb_pfm_boost_seq;

  localparam int TON   = 34;
  localparam int TOFF  = 13;
  localparam int TOFFA = 4;
  localparam int DTH   = 2;
  localparam int DTL   = 2;
  localparam int NVEC  = 5;
  // {limit arrival (k-th high cycle, 0 = never), expected on width}
  localparam int VEC [NVEC][2] = '{'{1, 3}, '{10, 12}, '{32, 34}, '{33, 34}, '{0, 34}};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic fb = 1'b0;
  logic ilim = 1'b0;
  logic zc = 1'b0;
  logic lsw, rect, a_lsw, a_rect;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  pfm_boost_seq dut (
    .clk(clk), .rst_n(rst_n), .en(en), .fb_low_i(fb), .ilim_i(ilim), .zc_i(zc),
    .lsw_gate_o(lsw), .rect_gate_o(rect)
  );

  pfm_boost_seq #(.TOFF_CYC(TOFFA), .DIODE_MODE(1)) dut_aux (
    .clk(clk), .rst_n(rst_n), .en(en), .fb_low_i(fb), .ilim_i(ilim), .zc_i(zc),
    .lsw_gate_o(a_lsw), .rect_gate_o(a_rect)
  );

  // waveform monitor, sampled at the falling edge
  int l_run = 0, r_run = 0, l_on_w = 0, l_off_w = 0, r_on_w = 0;
  int gap_dh = 0, gap_rl = 0, l_rises = 0, overlap = 0;
  int a_run = 0, a_on_w = 0, a_off_w = 0, a_rect_hi = 0;
  logic l_p = 1'b0, r_p = 1'b0, a_p = 1'b0;

  always @(negedge clk) begin
    if (lsw === 1'b1 && rect === 1'b1) overlap++;
    if (rect && !r_p) gap_dh = l_run;
    if (!rect && r_p) r_on_w = r_run;
    if (lsw && !l_p) begin gap_rl = r_run; l_off_w = l_run; l_rises++; end
    if (!lsw && l_p) l_on_w = l_run;
    l_run = (lsw == l_p) ? l_run + 1 : 1;
    r_run = (rect == r_p) ? r_run + 1 : 1;
    l_p = lsw;
    r_p = rect;
    if (a_rect === 1'b1) a_rect_hi++;
    if (a_lsw && !a_p) a_off_w = a_run;
    if (!a_lsw && a_p) a_on_w = a_run;
    a_run = (a_lsw == a_p) ? a_run + 1 : 1;
    a_p = a_lsw;
  end

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    int base;
    int lat;
    // R11: reset state
    repeat (3) tick();
    chk(lsw == 1'b0, "R11 lsw in reset", lsw, 0);
    chk(rect == 1'b0, "R11 rect in reset", rect, 0);
    rst_n = 1'b1;
    en = 1'b1;
    repeat (30) tick();
    // R1: no request, no pulse
    chk(l_rises == 0, "R1 no pulse without feedback low", l_rises, 0);

    // table walk: on width, limit, dead time, zero crossing
    for (int v = 0; v < NVEC; v++) begin
      int kv;
      int ex;
      int hi;
      kv = VEC[v][0];
      ex = VEC[v][1];
      fb = 1'b1;
      lat = 0;
      do begin tick(); lat++; end while (!lsw && lat < 50);
      chk(lat == 3, "R1 start latency", lat, 3);
      fb = 1'b0;
      hi = 1;
      forever begin
        if (hi == kv) ilim = 1'b1;
        tick();
        if (!lsw) break;
        hi++;
      end
      ilim = 1'b0;
      chk(l_on_w == ex, (kv == 0) ? "R2 on width" : "R3 limited width", l_on_w, ex);
      lat = 0;
      while (!rect && lat < 50) begin tick(); lat++; end
      chk(gap_dh == DTH, "R4 dead time before rectifier", gap_dh, DTH);
      zc = 1'b1;
      lat = 0;
      while (rect && lat < 50) begin tick(); lat++; end
      zc = 1'b0;
      chk(r_on_w == 3, "R6 zero-crossing turn-off", r_on_w, 3);
      repeat (20) tick();
      chk(rect == 1'b0 && lsw == 1'b0, "R6 rectifier stays off", rect, 0);
    end

    // continuous conduction with limit always active
    base = l_rises;
    fb = 1'b1;
    ilim = 1'b1;
    lat = 0;
    while (l_rises < base + 3 && lat < 300) begin tick(); lat++; end
    chk(l_on_w == 1, "R3 limit held high", l_on_w, 1);
    chk(l_off_w == TOFF + DTL, "R7 off time main", l_off_w, TOFF + DTL);
    chk(gap_rl == DTL, "R5 dead time before switch", gap_rl, DTL);
    chk(r_on_w == TOFF - DTH, "R5 rectifier cut by new cycle", r_on_w, TOFF - DTH);
    chk(a_on_w == 1, "R8 aux limited width", a_on_w, 1);
    chk(a_off_w == TOFFA, "R7 aux off time", a_off_w, TOFFA);

    // enable
    fb = 1'b0;
    ilim = 1'b0;
    repeat (30) tick();
    fb = 1'b1;
    lat = 0;
    while (!lsw && lat < 50) begin tick(); lat++; end
    en = 1'b0;
    tick();
    chk(lsw == 1'b0 && rect == 1'b0, "R9 forced off", {30'd0, lsw, rect}, 0);
    base = l_rises;
    repeat (40) tick();
    chk(l_rises == base, "R9 no pulse while disabled", l_rises, base);
    en = 1'b1;
    lat = 0;
    do begin tick(); lat++; end while (!lsw && lat < 50);
    chk(lat == 1, "R9 restart latency", lat, 1);
    fb = 1'b0;
    repeat (60) tick();

    chk(overlap == 0, "R10 gates overlap", overlap, 0);
    chk(a_rect_hi == 0, "R8 diode rectifier gate", a_rect_hi, 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule